// File: doc/BRIEF.md
# Reference-Based Frequency Range Monitor

This block sits beside a clock-recovery loop. It decides whether the recovered byte clock is running close enough to a local training reference. Every measurement window lasts a fixed number of recovered byte-clock cycles. During each window the block counts rising edges of the training reference and compares the total with an expected count. If the count is outside the tolerance band, the block asks the loop to follow the reference for one full window. It then releases the loop so that the loop can try to lock onto the incoming data again.

The training reference may run at the byte rate or at half the byte rate, selected by `half_rate`. The reference-edge count crosses into the byte-clock domain as a Gray code through a two-flop synchronizer, and each window's count is taken as the difference between two synchronized snapshots. An active-low link-fault output, `lfault_n`, is high only while the block considers the link locked. The channel-enable input `chan_en` overrides the measurement. A one-cycle `win_done` strobe and the measured `win_count` make every decision visible at the ports.

The controller has five states:
- `ST_OFF`: the channel is disabled, or the block is in reset.
- `ST_ACQUIRE`: first acquisition after reset or after the channel is enabled.
- `ST_LOCKED`: the link is considered locked.
- `ST_FORCE`: the loop is held on the reference for one window.
- `ST_RETRY`: the loop is released and measured again.

The transitions are:
- OFF→ACQUIRE when `chan_en` is high.
- Any state→OFF when `chan_en` is low.
- At the end of a window:
  - ACQUIRE stays in ACQUIRE when the count is out of range and moves to LOCKED when it is in range.
  - LOCKED stays in LOCKED when the count is in range and moves to FORCE when it is out of range.
  - FORCE always moves to RETRY.
  - RETRY moves to LOCKED when the count is in range and to FORCE when it is out of range.

Top module: `freq_range_monitor`

## Requirements
- R1: A window lasts exactly 4096 `byte_clk` cycles. The cycle after a window ends, `win_done` is high for one cycle and `win_count` holds the number of `ref_clk` rising edges in that window, give or take one edge of phase.
- R2: A count is in range when `half_rate`=0 and |count−4096| ≤ 6, or when `half_rate`=1 and |count−2048| ≤ 3.
- R3: An out-of-range window in ST_LOCKED moves the block to ST_FORCE, with `force_ref`=1, for exactly one window. At the end of that window it moves to ST_RETRY, with `force_ref`=0, whatever that window's count was.
- R4: `lfault_n` is 0 whenever `force_ref` is 1. `lfault_n` rises only in the cycle where `win_done` reports an in-range count, and it is 1 only in ST_LOCKED.
- R5: At the end of a window in ST_RETRY, an in-range count moves the block to ST_LOCKED and an out-of-range count moves it to ST_FORCE.
- R6: When `chan_en` is 0, the next cycle the block is in ST_OFF: `force_ref`=1, `lfault_n`=0, and `win_done` stays 0.
- R7: After reset or after the channel is re-enabled, the block stays in ST_ACQUIRE (`force_ref`=1, `lfault_n`=0) until it sees an in-range window. With an in-range reference applied, `lfault_n` rises within 4098 cycles.
- R8: If `chan_en` falls in the same cycle as a window end, disabling wins: no `win_done` pulse and no lock.
- R9: Successive values of the Gray-coded reference counter differ in at most one bit.
- R10: During reset, `force_ref`=1, `lfault_n`=0, `win_done`=0 and `win_count`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| byte_clk | input | 1 | Recovered byte clock; the measurement timebase |
| ref_clk | input | 1 | Local training reference clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| chan_en | input | 1 | Channel enable; 0 forces the OFF state |
| half_rate | input | 1 | 0: reference at byte rate; 1: reference at half the byte rate |
| force_ref | output | 1 | Request for the loop to track the reference |
| lfault_n | output | 1 | Active-low link fault; 1 means locked |
| win_done | output | 1 | One-cycle strobe after each completed window |
| win_count | output | 14 | Reference edges counted in the last window |

## Verification
A window end and a channel disable can fall in the same byte-clock cycle, and the state register then has two competing causes. The bench counts 4095 cycles after a `win_done` strobe and drops `chan_en` just before the edge that closes the next window. It then checks that no `win_done` appears and that the outputs show the OFF state, not a lock or a force decision. The bench also varies the reference period, both at random from a fixed seed and in directed steps, and judges each window's transition from the count the block itself reported.

// File: rtl/frm_pkg.sv
package frm_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_ACQUIRE,
        ST_LOCKED,
        ST_FORCE,
        ST_RETRY
    } mon_state_t;
endpackage

// File: rtl/ref_gray_counter.sv
module ref_gray_counter #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] gray_q
);
    logic [W-1:0] bin_q;
    logic [W-1:0] bin_nxt;

    assign bin_nxt = bin_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            bin_q  <= bin_nxt;
            gray_q <= bin_nxt ^ (bin_nxt >> 1);
        end
    end

    AST_GRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gray_q ^ $past(gray_q)) <= 1); // R9
endmodule

// File: rtl/gray_sync.sv
module gray_sync #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;
    logic [W-1:0] bin_c;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            bin_c[i] = ^(stab_q >> i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q  <= '0;
            stab_q  <= '0;
            bin_out <= '0;
        end else begin
            meta_q  <= gray_in;
            stab_q  <= meta_q;
            bin_out <= bin_c;
        end
    end
endmodule

// File: rtl/window_timer.sv
module window_timer #(
    parameter int WIN_LEN = 4096,
    localparam int WIN_W = $clog2(WIN_LEN)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic win_end
);
    localparam logic [WIN_W-1:0] LAST = WIN_W'(WIN_LEN - 1);
    logic [WIN_W-1:0] cnt_q;

    assign win_end = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || win_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_WIN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (cnt_q == '0)); // R1
endmodule

// File: rtl/freq_range_monitor.sv
module freq_range_monitor
    import frm_pkg::*;
#(
    parameter int WIN_LEN  = 4096,
    parameter int FULL_EXP = 4096,
    parameter int HALF_EXP = 2048,
    parameter int FULL_TOL = 6,
    parameter int HALF_TOL = 3,
    parameter int CNT_W    = 14
) (
    input  logic             byte_clk,
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             chan_en,
    input  logic             half_rate,
    output logic             force_ref,
    output logic             lfault_n,
    output logic             win_done,
    output logic [CNT_W-1:0] win_count
);
    localparam logic [CNT_W-1:0] FULL_LO = CNT_W'(FULL_EXP - FULL_TOL);
    localparam logic [CNT_W-1:0] FULL_HI = CNT_W'(FULL_EXP + FULL_TOL);
    localparam logic [CNT_W-1:0] HALF_LO = CNT_W'(HALF_EXP - HALF_TOL);
    localparam logic [CNT_W-1:0] HALF_HI = CNT_W'(HALF_EXP + HALF_TOL);

    mon_state_t state_q, state_nxt;

    logic [CNT_W-1:0] ref_gray;
    logic [CNT_W-1:0] sync_bin;
    logic [CNT_W-1:0] snap_q;
    logic [CNT_W-1:0] delta;
    logic             active;
    logic             win_end;
    logic             in_range;
    logic             close_win;

    // Reference domain: free-running Gray-coded edge counter
    ref_gray_counter #(.W(CNT_W)) u_refcnt (
        .clk    (ref_clk),
        .rst_n  (rst_n),
        .gray_q (ref_gray)
    );

    // Byte domain: two-flop synchronizer and Gray-to-binary decode
    gray_sync #(.W(CNT_W)) u_sync (
        .clk     (byte_clk),
        .rst_n   (rst_n),
        .gray_in (ref_gray),
        .bin_out (sync_bin)
    );

    assign active = (state_q != ST_OFF);

    window_timer #(.WIN_LEN(WIN_LEN)) u_timer (
        .clk     (byte_clk),
        .rst_n   (rst_n),
        .run     (active),
        .win_end (win_end)
    );

    assign delta     = sync_bin - snap_q;
    assign in_range  = half_rate ? (delta >= HALF_LO && delta <= HALF_HI)
                                 : (delta >= FULL_LO && delta <= FULL_HI);
    assign close_win = win_end && chan_en;

    // Snapshot of the synchronized count at each window start
    always_ff @(posedge byte_clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (!active || win_end) begin
            snap_q <= sync_bin;
        end
    end

    // Window result registers
    always_ff @(posedge byte_clk or negedge rst_n) begin
        if (!rst_n) begin
            win_done  <= 1'b0;
            win_count <= '0;
        end else begin
            win_done <= close_win;
            if (close_win) begin
                win_count <= delta;
            end
        end
    end

    // State register
    always_ff @(posedge byte_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Next-state logic; disable has priority over a window end
    always_comb begin
        state_nxt = state_q;
        if (!chan_en) begin
            state_nxt = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:     state_nxt = ST_ACQUIRE;
                ST_ACQUIRE: if (win_end) state_nxt = in_range ? ST_LOCKED : ST_ACQUIRE;
                ST_LOCKED:  if (win_end) state_nxt = in_range ? ST_LOCKED : ST_FORCE;
                ST_FORCE:   if (win_end) state_nxt = ST_RETRY;
                ST_RETRY:   if (win_end) state_nxt = in_range ? ST_LOCKED : ST_FORCE;
                default:    state_nxt = ST_OFF;
            endcase
        end
    end

    // Moore outputs
    always_comb begin
        force_ref = 1'b0;
        lfault_n  = 1'b0;
        unique case (state_q)
            ST_OFF:     force_ref = 1'b1;
            ST_ACQUIRE: force_ref = 1'b1;
            ST_LOCKED:  lfault_n  = 1'b1;
            ST_FORCE:   force_ref = 1'b1;
            ST_RETRY:   force_ref = 1'b0;
            default:    force_ref = 1'b1;
        endcase
    end

    AST_FORCE_MEANS_FAULT: assert property (@(posedge byte_clk) disable iff (!rst_n)
        force_ref |-> !lfault_n); // R4
    AST_LOCK_AT_WINDOW: assert property (@(posedge byte_clk) disable iff (!rst_n)
        $rose(lfault_n) |-> win_done); // R4
    AST_RELEASE_AT_WINDOW: assert property (@(posedge byte_clk) disable iff (!rst_n)
        $fell(force_ref) |-> win_done); // R3
    AST_DISABLE_FAULT: assert property (@(posedge byte_clk) disable iff (!rst_n)
        !chan_en |=> (!lfault_n && force_ref && !win_done)); // R6
    AST_DONE_SINGLE: assert property (@(posedge byte_clk) disable iff (!rst_n)
        win_done |=> !win_done); // R1
endmodule

// File: tb/freq_range_monitor_test.sv
`timescale 1ns/1ps
module freq_range_monitor_test;
    localparam int M_OFF = 0, M_ACQ = 1, M_LOCK = 2, M_FORCE = 3, M_RETRY = 4;

    logic        byte_clk = 1'b0;
    logic        ref_clk  = 1'b0;
    logic        rst_n    = 1'b0;
    logic        chan_en  = 1'b1;
    logic        half_rate = 1'b0;
    logic        force_ref, lfault_n, win_done;
    logic [13:0] win_count;

    real ref_half_ns = 4.0;
    int  checks = 0;
    int  fails  = 0;
    int  model  = M_OFF;
    int  exp_cnt = 4096;

    freq_range_monitor uut (
        .byte_clk (byte_clk),
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .chan_en  (chan_en),
        .half_rate(half_rate),
        .force_ref(force_ref),
        .lfault_n (lfault_n),
        .win_done (win_done),
        .win_count(win_count)
    );

    always #4 byte_clk = ~byte_clk;
    initial forever #(ref_half_ns) ref_clk = ~ref_clk;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic bit in_band(input int cnt, input bit hr);
        int d;
        d = hr ? cnt - 2048 : cnt - 4096;
        if (d < 0) d = -d;
        return hr ? (d <= 3) : (d <= 6);
    endfunction

    function automatic int next_model(input int m, input int cnt, input bit hr);
        bit ok;
        ok = in_band(cnt, hr);
        case (m)
            M_ACQ:   return ok ? M_LOCK : M_ACQ;
            M_LOCK:  return ok ? M_LOCK : M_FORCE;
            M_FORCE: return M_RETRY;
            M_RETRY: return ok ? M_LOCK : M_FORCE;
            default: return m;
        endcase
    endfunction

    task automatic set_ref(input bit hr, input int dev);
        int base;
        base = hr ? 2048 : 4096;
        half_rate   = hr;
        exp_cnt     = base + dev;
        ref_half_ns = 8.0 * 4096.0 / real'(base + dev) / 2.0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        do begin
            @(negedge byte_clk);
            cyc++;
        end while (!win_done);
    endtask

    task automatic run_window(input bit hr, input int dev, input string req);
        int cyc, cnt, d;
        set_ref(hr, dev);
        wait_done(cyc);
        cnt = int'(win_count);
        d = cnt - exp_cnt;
        if (d < 0) d = -d;
        chk(d <= 2, "R1 count", cnt, exp_cnt);
        model = next_model(model, cnt, hr);
        chk(force_ref == (model == M_ACQ || model == M_FORCE), req, int'(force_ref),
            int'(model == M_ACQ || model == M_FORCE));
        chk(lfault_n == (model == M_LOCK), req, int'(lfault_n), int'(model == M_LOCK));
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (190000) @(posedge byte_clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int cyc, seed, dev;
        bit hr, ok;
        seed = $urandom(20240611);
        set_ref(1'b0, 0);
        repeat (3) @(negedge byte_clk);
        // R10 reset state
        chk(force_ref == 1'b1, "R10 force", int'(force_ref), 1);
        chk(lfault_n == 1'b0, "R10 lfault", int'(lfault_n), 0);
        chk(win_done == 1'b0, "R10 done", int'(win_done), 0);
        chk(win_count == 14'd0, "R10 count", int'(win_count), 0);
        rst_n = 1'b1;
        model = M_ACQ;
        // R7 first lock within one window
        wait_done(cyc);
        chk(cyc <= 4098, "R7 lock time", cyc, 4098);
        chk(lfault_n == 1'b1, "R7 lfault", int'(lfault_n), 1);
        model = M_LOCK;

        // R3/R5 directed sequence at full rate
        run_window(1'b0, 15, "R3 enter force");
        run_window(1'b0, 15, "R3 release after one window");
        run_window(1'b0, 15, "R5 retry fails");
        run_window(1'b0, 0, "R3 release");
        run_window(1'b0, 0, "R5 retry locks");
        // R2 half-rate
        run_window(1'b1, 0, "R2 half in range");
        run_window(1'b1, 9, "R2 half out of range");
        run_window(1'b1, -9, "R2 half out of range low");
        run_window(1'b1, 0, "R2 half relock");
        run_window(1'b0, -14, "R2 full low side");
        run_window(1'b0, 3, "R2 full in band");
        run_window(1'b0, 3, "R2 full relock");

        // Random windows
        for (int i = 0; i < 10; i++) begin
            hr = 1'($urandom % 2);
            ok = 1'($urandom % 3 != 0);
            if (ok) begin
                dev = hr ? 0 : int'($urandom % 7) - 3;
            end else begin
                dev = (hr ? 7 : 10) + int'($urandom % 20);
                if ($urandom % 2 == 1) dev = -dev;
            end
            run_window(hr, dev, "R5 random window");
        end

        // R6 disable
        set_ref(1'b0, 0);
        @(negedge byte_clk);
        chan_en = 1'b0;
        @(negedge byte_clk);
        chk(force_ref == 1'b1, "R6 force", int'(force_ref), 1);
        chk(lfault_n == 1'b0, "R6 lfault", int'(lfault_n), 0);
        for (int i = 0; i < 20; i++) begin
            @(negedge byte_clk);
            chk(win_done == 1'b0, "R6 no strobe", int'(win_done), 0);
        end
        chan_en = 1'b1;
        model = M_ACQ;
        repeat (100) @(negedge byte_clk);
        chk(lfault_n == 1'b0 && force_ref == 1'b1, "R7 acquire holds", int'(lfault_n), 0);
        wait_done(cyc);
        chk(cyc <= 4000, "R7 relock time", cyc, 4000);
        chk(lfault_n == 1'b1, "R7 relock", int'(lfault_n), 1);
        model = M_LOCK;

        // R8 disable on the closing edge of a window
        repeat (4095) @(posedge byte_clk);
        @(negedge byte_clk);
        chk(win_done == 1'b0, "R8 pre-edge", int'(win_done), 0);
        chan_en = 1'b0;
        @(negedge byte_clk);
        chk(win_done == 1'b0, "R8 no strobe", int'(win_done), 0);
        chk(force_ref == 1'b1 && lfault_n == 1'b0, "R8 off state", int'(lfault_n), 0);
        chan_en = 1'b1;
        model = M_ACQ;
        run_window(1'b0, 20, "R7 acquire stays");
        run_window(1'b0, 0, "R7 acquire locks");

        summary();
        $finish;
    end
endmodule